// File: doc/BRIEF.md
# Serial Receiver Bit and Word Alignment Controller

This block trains a 7:1 source-synchronous LVDS receiver. It sits behind a 1:7 deserializer whose fast capture clock is the forwarded slow clock multiplied by 3.5. Each slow-clock cycle the deserializer hands over one 7-bit word. That word comes from the forwarded clock lane, which is deserialized exactly like a data lane and serves as the reference for training.

Training runs in two steps. The first is bit alignment. The controller steps a 16-position sampling phase selector through every position, lets each one settle, and then watches the clock-lane word. A phase passes when the word stays constant over the whole observation window. The controller then picks the phase at the middle of the longest circular run of passing phases, which places the capture edge at the centre of the eye. The second step is word alignment. The controller issues single-cycle slip pulses, one at a time, until the clock-lane word equals the framing pattern. The flags report success or failure, and a start request reruns the whole procedure.

Top module: `lvds_align_ctrl`

## Requirements
- R1: While reset is high and after it is released, `phase_sel_o` is 0 and `phase_step_o`, `word_slip_o`, `done_o` and `error_o` are all 0 until a start request arrives.
- R2: A start request loads phase 0. The sweep then visits phases 1 to 15 in increasing order. `phase_step_o` pulses for one cycle in each cycle that `phase_sel_o` is loaded, so a run that reaches word alignment produces exactly 17 pulses (16 sweep loads and 1 centre load).
- R3: Each swept phase is held for exactly 80 cycles: 16 settle cycles followed by 64 observation cycles.
- R4: Changes of the clock-lane word during the 16 settle cycles after a phase change do not affect whether that phase passes.
- R5: A phase passes only if the clock-lane word is identical in all 64 observation cycles. A single differing cycle fails the phase.
- R6: After the sweep, `phase_sel_o` is loaded with (s + (L-1)/2) mod 16. Here s is the first phase of the longest run of passing phases, treating phase 15 and phase 0 as neighbours, and L is the length of that run. When two runs are equally long, the run with the lower s wins. When all 16 phases pass, the value is 7.
- R7: If no phase passes, `error_o` rises, `done_o` stays 0, no slip pulse is issued, and `phase_sel_o` stays at 15.
- R8: Word alignment begins at the centre load. The block waits 4 cycles and then compares the clock-lane word with 7'b1100011. On a mismatch it issues a slip, waits 4 more cycles and compares again. On a match `done_o` rises.
- R9: If the word still does not match after 7 slips, `error_o` rises and `done_o` stays 0.
- R10: `word_slip_o` is never high for two consecutive cycles. Consecutive slips are exactly 5 cycles apart.
- R11: A start request, including one made during a sweep or after an error, clears `done_o` and `error_o` and sets `phase_sel_o` to 0 in the next cycle, then reruns the whole sequence.
- R12: `done_o` and `error_o` are never both high, and `phase_sel_o` does not change during word alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow parallel clock (fast capture clock divided by 3.5) |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request; reruns the full training sequence |
| lane_word_i | input | 7 | Deserialized clock-lane word |
| phase_sel_o | output | 4 | Sampling phase selector |
| phase_step_o | output | 1 | One-cycle strobe when the phase selector is loaded |
| word_slip_o | output | 1 | One-cycle word-boundary slip pulse |
| done_o | output | 1 | Both alignment steps completed |
| error_o | output | 1 | No passing phase, or no framing match after all slips |

## Verification
The bench builds the block with its default parameters: 16 phases, 16 settle cycles, 64 observation cycles, a 4-cycle wait after each slip and at most 7 slips. With these values a full sweep takes about 1,300 cycles, so nine complete training runs fit easily. Its lane model assigns each phase a behaviour: clean, noisy, noisy during the first few settle cycles only, or a single glitch at observation age 40. These behaviours let the bench exercise the wrap-around run, the tie between equal runs, the all-pass case and the settle-versus-observe boundary. A rotating word offset of 0, 3, 6, 5 or 2 slips, together with a framing word that never matches, covers both the successful and the failing ends of word alignment.

// File: rtl/align_pkg.sv
package align_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SWEEP,
    ST_CENTER,
    ST_FRAME
  } ctrl_state_t;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_WAIT,
    FR_CMP
  } frame_state_t;
endpackage

// File: rtl/phase_sweep.sv
module phase_sweep #(
  parameter int NPHASE      = 16,
  parameter int WORD_W      = 7,
  parameter int SETTLE_CYC  = 16,
  parameter int OBSERVE_CYC = 64,
  localparam int PW   = $clog2(NPHASE),
  localparam int HOLD = SETTLE_CYC + OBSERVE_CYC,
  localparam int CW   = $clog2(HOLD + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kick_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [PW-1:0]     phase_o,
  output logic              adv_o,
  output logic              done_o,
  output logic [NPHASE-1:0] pass_map_o
);
  logic              active_q;
  logic [CW-1:0]     cnt_q;
  logic [WORD_W-1:0] ref_q;
  logic              ok_q;
  logic [PW-1:0]     phase_q;
  logic [NPHASE-1:0] pass_q;
  logic              done_q;
  logic              last_cyc;

  assign last_cyc   = active_q && (cnt_q == CW'(HOLD - 1));
  assign adv_o      = last_cyc && (phase_q != PW'(NPHASE - 1));
  assign phase_o    = phase_q;
  assign done_o     = done_q;
  assign pass_map_o = pass_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      ref_q    <= '0;
      ok_q     <= 1'b1;
      phase_q  <= '0;
      pass_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (kick_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        phase_q  <= '0;
        pass_q   <= '0;
        ok_q     <= 1'b1;
      end else if (active_q) begin
        if (cnt_q == CW'(SETTLE_CYC)) begin
          ref_q <= word_i;
        end else if (cnt_q > CW'(SETTLE_CYC) && word_i != ref_q) begin
          ok_q <= 1'b0;
        end
        if (last_cyc) begin
          pass_q[phase_q] <= ok_q && (word_i == ref_q);
          cnt_q           <= '0;
          ok_q            <= 1'b1;
          if (phase_q == PW'(NPHASE - 1)) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            phase_q <= phase_q + 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R3
  hold_window_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q != $past(phase_q)) && !$past(kick_i) |-> $past(cnt_q) == CW'(HOLD - 1));

  // R2
  sweep_order_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q != $past(phase_q)) && !$past(kick_i) |-> phase_q == $past(phase_q) + 1'b1);
endmodule

// File: rtl/eye_center.sv
module eye_center #(
  parameter int NPHASE = 16,
  localparam int PW = $clog2(NPHASE)
) (
  input  logic [NPHASE-1:0] pass_i,
  output logic [PW-1:0]     center_o,
  output logic              any_o
);
  always_comb begin
    int   best_len;
    int   best_s;
    int   len;
    logic run;
    best_len = 0;
    best_s   = 0;
    len      = 0;
    run      = 1'b0;
    any_o    = |pass_i;
    if (&pass_i) begin
      best_len = NPHASE;
      best_s   = 0;
    end else begin
      for (int s = 0; s < NPHASE; s++) begin
        if (pass_i[s] && !pass_i[(s + NPHASE - 1) % NPHASE]) begin
          len = 0;
          run = 1'b1;
          for (int k = 0; k < NPHASE; k++) begin
            if (run && pass_i[(s + k) % NPHASE]) len = len + 1;
            else run = 1'b0;
          end
          if (len > best_len) begin
            best_len = len;
            best_s   = s;
          end
        end
      end
    end
    if (best_len > 0) center_o = PW'((best_s + (best_len - 1) / 2) % NPHASE);
    else center_o = '0;
  end

  // R6
  always_comb begin
    center_pass_chk: assert (!any_o || pass_i[center_o]);
  end
endmodule

// File: rtl/word_framer.sv
module word_framer import align_pkg::*; #(
  parameter int WORD_W    = 7,
  parameter logic [WORD_W-1:0] FRAME_PAT = 'b1100011,
  parameter int SLIP_WAIT = 4,
  parameter int MAX_SLIPS = 7,
  localparam int SW = $clog2(MAX_SLIPS + 1),
  localparam int WW = $clog2(SLIP_WAIT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              kick_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              slip_o,
  output logic              match_o,
  output logic              fail_o
);
  frame_state_t  st_q;
  logic [WW-1:0] wait_q;
  logic [SW-1:0] slips_q;
  logic          slip_q, match_q, fail_q;

  assign slip_o  = slip_q;
  assign match_o = match_q;
  assign fail_o  = fail_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      st_q    <= FR_IDLE;
      wait_q  <= '0;
      slips_q <= '0;
      slip_q  <= 1'b0;
      match_q <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      slip_q  <= 1'b0;
      match_q <= 1'b0;
      fail_q  <= 1'b0;
      case (st_q)
        FR_IDLE: if (kick_i) begin
          st_q    <= FR_WAIT;
          wait_q  <= '0;
          slips_q <= '0;
        end
        FR_WAIT: begin
          if (wait_q == WW'(SLIP_WAIT - 1)) st_q <= FR_CMP;
          else wait_q <= wait_q + 1'b1;
        end
        FR_CMP: begin
          if (word_i == FRAME_PAT) begin
            match_q <= 1'b1;
            st_q    <= FR_IDLE;
          end else if (slips_q == SW'(MAX_SLIPS)) begin
            fail_q <= 1'b1;
            st_q   <= FR_IDLE;
          end else begin
            slip_q  <= 1'b1;
            slips_q <= slips_q + 1'b1;
            wait_q  <= '0;
            st_q    <= FR_WAIT;
          end
        end
        default: st_q <= FR_IDLE;
      endcase
    end
  end

  // R10
  slip_single_chk: assert property (@(posedge clk) disable iff (rst)
    slip_q |=> !slip_q);

  // R9
  slip_cap_chk: assert property (@(posedge clk) disable iff (rst)
    fail_q |-> $past(slips_q) == SW'(MAX_SLIPS));
endmodule

// File: rtl/lvds_align_ctrl.sv
module lvds_align_ctrl import align_pkg::*; #(
  parameter int NPHASE      = 16,
  parameter int WORD_W      = 7,
  parameter int SETTLE_CYC  = 16,
  parameter int OBSERVE_CYC = 64,
  parameter int SLIP_WAIT   = 4,
  parameter int MAX_SLIPS   = 7,
  parameter logic [WORD_W-1:0] FRAME_PAT = 'b1100011,
  localparam int PW = $clog2(NPHASE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [WORD_W-1:0] lane_word_i,
  output logic [PW-1:0]     phase_sel_o,
  output logic              phase_step_o,
  output logic              word_slip_o,
  output logic              done_o,
  output logic              error_o
);
  ctrl_state_t       state_q;
  logic [PW-1:0]     phase_q;
  logic              step_q, done_q, err_q;
  logic [PW-1:0]     sweep_phase;
  logic              sweep_adv, sweep_done;
  logic [NPHASE-1:0] pass_map;
  logic [PW-1:0]     center;
  logic              any_pass;
  logic              frame_kick, frame_match, frame_fail;

  assign frame_kick = (state_q == ST_CENTER) && any_pass && !start_i;

  phase_sweep #(
    .NPHASE(NPHASE), .WORD_W(WORD_W),
    .SETTLE_CYC(SETTLE_CYC), .OBSERVE_CYC(OBSERVE_CYC)
  ) u_sweep (
    .clk(clk), .rst(rst), .kick_i(start_i), .word_i(lane_word_i),
    .phase_o(sweep_phase), .adv_o(sweep_adv), .done_o(sweep_done),
    .pass_map_o(pass_map)
  );

  eye_center #(.NPHASE(NPHASE)) u_center (
    .pass_i(pass_map), .center_o(center), .any_o(any_pass)
  );

  word_framer #(
    .WORD_W(WORD_W), .FRAME_PAT(FRAME_PAT),
    .SLIP_WAIT(SLIP_WAIT), .MAX_SLIPS(MAX_SLIPS)
  ) u_framer (
    .clk(clk), .rst(rst), .clear_i(start_i), .kick_i(frame_kick),
    .word_i(lane_word_i), .slip_o(word_slip_o),
    .match_o(frame_match), .fail_o(frame_fail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      step_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      step_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_SWEEP;
        phase_q <= '0;
        step_q  <= 1'b1;
        done_q  <= 1'b0;
        err_q   <= 1'b0;
      end else begin
        case (state_q)
          ST_SWEEP: begin
            if (sweep_adv) begin
              phase_q <= phase_q + 1'b1;
              step_q  <= 1'b1;
            end
            if (sweep_done) state_q <= ST_CENTER;
          end
          ST_CENTER: begin
            if (any_pass) begin
              phase_q <= center;
              step_q  <= 1'b1;
              state_q <= ST_FRAME;
            end else begin
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
          ST_FRAME: begin
            if (frame_match) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (frame_fail) begin
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign phase_sel_o  = phase_q;
  assign phase_step_o = step_q;
  assign done_o       = done_q;
  assign error_o      = err_q;

  // R12
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_q && err_q));

  // R12
  frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FRAME) && ($past(state_q) == ST_FRAME) |-> $stable(phase_q));

  // R2
  sweep_track_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SWEEP) |-> phase_q == sweep_phase);

  // R11
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (phase_q == '0) && !done_q && !err_q && step_q);

  // R8
  slip_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    word_slip_o |-> state_q == ST_FRAME);
endmodule

// File: tb/tb_lvds_align_ctrl.sv
module tb_lvds_align_ctrl;
  localparam logic [6:0] PAT = 7'b1100011;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [6:0] lane_word_i = '0;
  logic [3:0] phase_sel_o;
  logic       phase_step_o, word_slip_o, done_o, error_o;

  int tests = 0, fails = 0;
  int steps = 0, slips = 0, cyc = 0, last_step = 0, last_slip = 0, age = 0;
  bit gap_bad = 0, slip_gap_bad = 0, badframe = 0;
  int offset = 0;
  logic [6:0] noise = '0;
  logic [1:0] mode [16];

  always #2 clk = ~clk;

  lvds_align_ctrl dut (
    .clk(clk), .rst(rst), .start_i(start_i), .lane_word_i(lane_word_i),
    .phase_sel_o(phase_sel_o), .phase_step_o(phase_step_o),
    .word_slip_o(word_slip_o), .done_o(done_o), .error_o(error_o)
  );

  function automatic logic [6:0] rotl7(logic [6:0] w, int n);
    logic [6:0] r = w;
    for (int i = 0; i < n; i++) r = {r[5:0], r[6]};
    return r;
  endfunction

  // lane model: 0 noisy, 1 clean, 2 noisy early in settle, 3 glitch at age 40
  always @(negedge clk) begin
    logic [6:0] frame;
    cyc++;
    noise = noise + 1'b1;
    if (phase_step_o) begin
      steps++;
      if (steps >= 2 && steps <= 16 && (cyc - last_step) != 80) gap_bad = 1;
      last_step = cyc;
      age = 0;
    end else age++;
    if (word_slip_o) begin
      slips++;
      if (slips >= 2 && (cyc - last_slip) != 5) slip_gap_bad = 1;
      last_slip = cyc;
      offset = (offset + 1) % 7;
    end
    frame = badframe ? 7'b0101010 : rotl7(PAT, offset);
    case (mode[phase_sel_o])
      2'd0: lane_word_i = noise;
      2'd1: lane_word_i = frame;
      2'd2: lane_word_i = (age < 3) ? noise : frame;
      default: lane_word_i = (age == 40) ? ~frame : frame;
    endcase
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_modes(input logic [15:0] clean, input logic [15:0] settle, input logic [15:0] glitch);
    for (int i = 0; i < 16; i++)
      mode[i] = glitch[i] ? 2'd3 : settle[i] ? 2'd2 : clean[i] ? 2'd1 : 2'd0;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1;
    steps = 0; slips = 0; gap_bad = 0; slip_gap_bad = 0;
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic run_case(input string name, input int off, input bit bad, input int exp_ph,
                          input int exp_slips, input bit exp_done, input bit exp_err, input int exp_steps);
    int t;
    offset = off;
    badframe = bad;
    pulse_start();
    t = 0;
    while (!(done_o || error_o) && t < 4000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    #1;
    $display("[TB] case %s", name);
    chk(done_o == exp_done, "R8", "done", done_o, exp_done);
    chk(error_o == exp_err, "R9", "error", error_o, exp_err);
    chk(phase_sel_o == 4'(exp_ph), "R6", "phase", phase_sel_o, exp_ph);
    chk(slips == exp_slips, "R8", "slips", slips, exp_slips);
    chk(steps == exp_steps, "R2", "steps", steps, exp_steps);
    chk(!gap_bad, "R3", "hold gap", gap_bad, 0);
    chk(!slip_gap_bad, "R10", "slip gap", slip_gap_bad, 0);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk(phase_sel_o == 0 && !phase_step_o && !word_slip_o && !done_o && !error_o,
        "R1", "reset outputs", {phase_sel_o, phase_step_o, word_slip_o, done_o, error_o}, 0);
    @(posedge clk); #1 rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(phase_sel_o == 0 && !done_o && !error_o && steps == 0, "R1", "idle after reset",
        steps, 0);
  endtask

  task automatic t_restart();
    // starts from an error state; restart mid-sweep
    set_modes(16'h01F8, 16'h0000, 16'h0000);
    pulse_start();
    @(negedge clk); #1;
    chk(!error_o && !done_o && phase_sel_o == 0, "R11", "cleared after start", error_o, 0);
    repeat (300) @(negedge clk);
    chk(phase_sel_o == 3, "R11", "mid-sweep phase", phase_sel_o, 3);
    run_case("restart", 0, 0, 5, 0, 1, 0, 17);
  endtask

  initial begin
    set_modes(16'h0000, 16'h0000, 16'h0000);
    t_reset();
    set_modes(16'hFFFF, 16'h0000, 16'h0000);
    run_case("all pass", 3, 0, 7, 4, 1, 0, 17);            // R6 R8
    set_modes(16'h01F8, 16'h0000, 16'h0000);
    run_case("run 3..8", 0, 0, 5, 0, 1, 0, 17);            // R6
    set_modes(16'hE063, 16'h0000, 16'h0000);
    run_case("wrap", 6, 0, 15, 1, 1, 0, 17);               // R6 circular
    set_modes(16'h0E1C, 16'h0000, 16'h0000);
    run_case("tie", 5, 0, 3, 2, 1, 0, 17);                 // R6 tie
    set_modes(16'h0000, 16'h0FF0, 16'h0000);
    run_case("settle noise", 2, 0, 7, 5, 1, 0, 17);        // R4
    set_modes(16'h0BF0, 16'h0000, 16'h0400);
    run_case("observe glitch", 0, 0, 6, 0, 1, 0, 17);      // R5
    set_modes(16'h0000, 16'h0000, 16'h0000);
    run_case("no pass", 0, 0, 15, 0, 0, 1, 16);            // R7
    set_modes(16'hFFFF, 16'h0000, 16'h0000);
    run_case("bad frame", 0, 1, 7, 7, 0, 1, 17);           // R9
    t_restart();                                           // R11
    chk(!(done_o && error_o), "R12", "flags exclusive", done_o + error_o, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule